// File: doc/BRIEF.md
# Warp Issue Scheduler with Block Barriers

This block chooses which resident warp issues on an eight-lane SIMD multiprocessor. A warp of 32 threads takes four consecutive cycles (beats) of eight threads each to issue one instruction. At each instruction boundary the scheduler may move to any eligible warp of any resident thread block, with no bubble between instructions. A warp is eligible when it is resident, its operands are marked ready, and it is not held at a barrier.

Thread blocks are made resident by a launch strobe that carries a block number and the set of warp slots the block occupies, and are removed by a retire strobe. A warp that reaches a barrier raises its arrival request and is held out of selection. Once every resident warp of its block has arrived, the whole block is released, and the final arrival is never held. Warps of other blocks keep issuing while a block waits.

Top module: `warp_issue_sched`

## Requirements
- R1: During and right after reset no instruction issues: issue_valid_o is 0, stall_o is 1, issue_beat_o is 0 and no warp slot is resident.
- R2: Each issued instruction shows issue_valid_o high for exactly four consecutive cycles, with issue_beat_o counting 0, 1, 2, 3 and issue_warp_o unchanged.
- R3: In the cycle after beat 3, or after an idle cycle, a new instruction starts at beat 0 whenever some warp was eligible at that clock edge.
- R4: A warp is eligible only if it is resident, its warp_ready_i bit is 1 and it is not held at a barrier; block membership does not restrict eligibility.
- R5: Among eligible warps, the scheduler picks the first in ascending slot order, wrapping, after the warp that last started an instruction. After reset the search starts at slot 0.
- R6: stall_o is 1 exactly in the cycles in which issue_valid_o is 0.
- R7: An accepted arrival holds its warp out of selection from the same clock edge on. When the held warps plus the arrivals in the current cycle cover every resident warp of that block, all of that block's warps are eligible at that same edge and its barrier state is cleared.
- R8: Warps of blocks that are not waiting at a barrier keep issuing while another block is held.
- R9: A retire strobe removes every resident warp of the named block and clears their barrier state. An instruction already in flight finishes its beats, but no new instruction of those warps starts afterwards. A launch assigns its mask bits to the named block, makes them resident at the next edge and clears their barrier state.
- R10: An arrival request from a warp that is not resident, or from a warp already held at the barrier, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| warp_ready_i | input | 24 | Operand-ready flag per warp slot |
| bar_arrive_i | input | 24 | Barrier arrival request per warp slot |
| launch_valid_i | input | 1 | Make a block resident this cycle |
| launch_block_i | input | 3 | Block number for the launch |
| launch_mask_i | input | 24 | Warp slots the launched block occupies |
| retire_valid_i | input | 1 | Remove a block this cycle |
| retire_block_i | input | 3 | Block number to remove |
| issue_valid_o | output | 1 | An instruction beat issues this cycle |
| issue_warp_o | output | 5 | Warp slot being issued |
| issue_beat_o | output | 2 | Lane-group beat of the current instruction |
| stall_o | output | 1 | No warp issues this cycle |

## Verification
The hardest state to reach is a barrier that has to survive a block boundary. Part of a block has arrived, the block is retired and a block is relaunched into the same slots. A stale arrival count would then release the relaunched block early or keep it held forever. The stimulus builds this sequence on purpose: two warps arrive, the block is retired and relaunched, and four warps arrive before the last two. A behavioural model compares every beat against the design, so any leftover barrier state shows up as a wrong warp number. Directed windows also hold one block at a barrier while another keeps issuing, repeat arrivals from held and non-resident warps, and starve the ready flags down to a single warp.

// File: rtl/wis_pkg.sv
package wis_pkg;
  localparam int unsigned WIS_WARPS  = 24;
  localparam int unsigned WIS_BLOCKS = 8;
  localparam int unsigned WIS_BEATS  = 4;

  // population count over a warp vector, shared by barrier bookkeeping
  function automatic int unsigned wis_popcnt(input logic [WIS_WARPS-1:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < WIS_WARPS; i++) n += int'(v[i]);
    return n;
  endfunction
endpackage

// File: rtl/wis_resident_tbl.sv
module wis_resident_tbl #(
  parameter int unsigned NUM_WARPS  = wis_pkg::WIS_WARPS,
  parameter int unsigned NUM_BLOCKS = wis_pkg::WIS_BLOCKS,
  localparam int unsigned BLK_W     = $clog2(NUM_BLOCKS)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            launch_valid_i,
  input  logic [BLK_W-1:0]                launch_block_i,
  input  logic [NUM_WARPS-1:0]            launch_mask_i,
  input  logic                            retire_valid_i,
  input  logic [BLK_W-1:0]                retire_block_i,
  output logic [NUM_WARPS-1:0]            resident_o,
  output logic [NUM_WARPS-1:0][BLK_W-1:0] blk_of_o,
  output logic [NUM_WARPS-1:0]            retire_mask_o,
  output logic [NUM_WARPS-1:0]            launch_eff_o
);
  logic [NUM_WARPS-1:0]            resident_q;
  logic [NUM_WARPS-1:0][BLK_W-1:0] blk_of_q;

  assign launch_eff_o = launch_valid_i ? launch_mask_i : '0;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_ret
    assign retire_mask_o[w] = retire_valid_i && resident_q[w] &&
                              (blk_of_q[w] == retire_block_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resident_q <= '0;
      blk_of_q   <= '0;
    end else begin
      resident_q <= (resident_q & ~retire_mask_o) | launch_eff_o;
      for (int w = 0; w < NUM_WARPS; w++)
        if (launch_eff_o[w]) blk_of_q[w] <= launch_block_i;
    end
  end

  assign resident_o = resident_q;
  assign blk_of_o   = blk_of_q;

  AST_RETIRE_GONE: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_valid_i && !launch_valid_i) |=> ((resident_q & $past(retire_mask_o)) == '0)); // R9
endmodule

// File: rtl/wis_barrier.sv
module wis_barrier #(
  parameter int unsigned NUM_WARPS  = wis_pkg::WIS_WARPS,
  parameter int unsigned NUM_BLOCKS = wis_pkg::WIS_BLOCKS,
  localparam int unsigned BLK_W     = $clog2(NUM_BLOCKS)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_WARPS-1:0]            resident_i,
  input  logic [NUM_WARPS-1:0][BLK_W-1:0] blk_of_i,
  input  logic [NUM_WARPS-1:0]            arrive_i,
  input  logic [NUM_WARPS-1:0]            retire_mask_i,
  input  logic [NUM_WARPS-1:0]            launch_mask_i,
  output logic [NUM_WARPS-1:0]            held_nx_o,
  output logic [NUM_BLOCKS-1:0]           release_o
);
  import wis_pkg::wis_popcnt;

  logic [NUM_WARPS-1:0]                  held_q;
  logic [NUM_WARPS-1:0]                  arr_new;
  logic [NUM_WARPS-1:0]                  held_pre;
  logic [NUM_WARPS-1:0]                  release_mask;
  logic [NUM_BLOCKS-1:0][NUM_WARPS-1:0]  member;

  // arrivals only count for resident warps that are not already held
  assign arr_new  = arrive_i & resident_i & ~held_q;
  assign held_pre = held_q | arr_new;

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_mem
      assign member[b][w] = resident_i[w] && (blk_of_i[w] == BLK_W'(b));
    end
    assign release_o[b] = (member[b] != '0) &&
      (wis_popcnt(held_pre & member[b]) == wis_popcnt(member[b]));
  end

  always_comb begin
    release_mask = '0;
    for (int b = 0; b < NUM_BLOCKS; b++)
      if (release_o[b]) release_mask |= member[b];
  end

  assign held_nx_o = held_pre & ~release_mask & ~retire_mask_i & ~launch_mask_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_nx_o;
  end

  AST_HELD_RESIDENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((held_q & ~resident_i) == '0)); // R9
  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (|release_o) |=> ((held_q & $past(release_mask)) == '0)); // R7
  AST_REPEAT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    ((arr_new & held_q) == '0)); // R10
endmodule

// File: rtl/wis_issue_seq.sv
module wis_issue_seq #(
  parameter int unsigned NUM_WARPS = wis_pkg::WIS_WARPS,
  parameter int unsigned BEATS     = wis_pkg::WIS_BEATS,
  localparam int unsigned WARP_W   = $clog2(NUM_WARPS),
  localparam int unsigned BEAT_W   = $clog2(BEATS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WARPS-1:0] elig_i,
  output logic                 active_o,
  output logic [WARP_W-1:0]    warp_o,
  output logic [BEAT_W-1:0]    beat_o
);
  logic              active_q;
  logic [BEAT_W-1:0] beat_q;
  logic [WARP_W-1:0] cur_q;
  logic [WARP_W-1:0] last_q;
  logic              slot_free;
  logic              any_elig;
  logic              take_w;
  logic [WARP_W-1:0] pick_w;

  // first set bit of m strictly after position last, wrapping
  function automatic logic [WARP_W-1:0] rr_pick(input logic [NUM_WARPS-1:0] m,
                                                input logic [WARP_W-1:0]    last);
    logic found;
    logic [WARP_W-1:0] sel;
    found = 1'b0;
    sel   = '0;
    for (int i = 1; i <= NUM_WARPS; i++) begin
      int idx;
      idx = (int'(last) + i) % NUM_WARPS;
      if (!found && m[idx]) begin
        found = 1'b1;
        sel   = WARP_W'(idx);
      end
    end
    return sel;
  endfunction

  assign slot_free = !active_q || (beat_q == BEAT_W'(BEATS - 1));
  assign any_elig  = |elig_i;
  assign take_w    = slot_free && any_elig;
  assign pick_w    = rr_pick(elig_i, last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      cur_q    <= '0;
      last_q   <= WARP_W'(NUM_WARPS - 1);
    end else if (slot_free) begin
      beat_q <= '0;
      if (any_elig) begin
        active_q <= 1'b1;
        cur_q    <= pick_w;
        last_q   <= pick_w;
      end else begin
        active_q <= 1'b0;
      end
    end else begin
      beat_q <= beat_q + BEAT_W'(1);
    end
  end

  assign active_o = active_q;
  assign warp_o   = cur_q;
  assign beat_o   = beat_q;

  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && beat_q != BEAT_W'(BEATS - 1)) |=>
      (active_q && beat_q == $past(beat_q) + BEAT_W'(1) && cur_q == $past(cur_q))); // R2
  AST_NO_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_free && any_elig) |=> (active_q && beat_q == '0)); // R3
  AST_PICK_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |-> elig_i[pick_w]); // R4
  AST_IDLE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> (beat_q == '0)); // R6
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
  parameter int unsigned NUM_WARPS  = wis_pkg::WIS_WARPS,
  parameter int unsigned NUM_BLOCKS = wis_pkg::WIS_BLOCKS,
  parameter int unsigned BEATS      = wis_pkg::WIS_BEATS,
  localparam int unsigned WARP_W    = $clog2(NUM_WARPS),
  localparam int unsigned BLK_W     = $clog2(NUM_BLOCKS),
  localparam int unsigned BEAT_W    = $clog2(BEATS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WARPS-1:0] warp_ready_i,
  input  logic [NUM_WARPS-1:0] bar_arrive_i,
  input  logic                 launch_valid_i,
  input  logic [BLK_W-1:0]     launch_block_i,
  input  logic [NUM_WARPS-1:0] launch_mask_i,
  input  logic                 retire_valid_i,
  input  logic [BLK_W-1:0]     retire_block_i,
  output logic                 issue_valid_o,
  output logic [WARP_W-1:0]    issue_warp_o,
  output logic [BEAT_W-1:0]    issue_beat_o,
  output logic                 stall_o
);
  logic [NUM_WARPS-1:0]            resident_w;
  logic [NUM_WARPS-1:0][BLK_W-1:0] blk_of_w;
  logic [NUM_WARPS-1:0]            retire_mask_w;
  logic [NUM_WARPS-1:0]            launch_eff_w;
  logic [NUM_WARPS-1:0]            held_nx_w;
  logic [NUM_BLOCKS-1:0]           release_w;
  logic [NUM_WARPS-1:0]            elig_w;
  logic                            active_w;

  wis_resident_tbl #(.NUM_WARPS(NUM_WARPS), .NUM_BLOCKS(NUM_BLOCKS)) u_res (
    .clk            (clk),
    .rst_n          (rst_n),
    .launch_valid_i (launch_valid_i),
    .launch_block_i (launch_block_i),
    .launch_mask_i  (launch_mask_i),
    .retire_valid_i (retire_valid_i),
    .retire_block_i (retire_block_i),
    .resident_o     (resident_w),
    .blk_of_o       (blk_of_w),
    .retire_mask_o  (retire_mask_w),
    .launch_eff_o   (launch_eff_w)
  );

  wis_barrier #(.NUM_WARPS(NUM_WARPS), .NUM_BLOCKS(NUM_BLOCKS)) u_bar (
    .clk           (clk),
    .rst_n         (rst_n),
    .resident_i    (resident_w),
    .blk_of_i      (blk_of_w),
    .arrive_i      (bar_arrive_i),
    .retire_mask_i (retire_mask_w),
    .launch_mask_i (launch_eff_w),
    .held_nx_o     (held_nx_w),
    .release_o     (release_w)
  );

  // eligibility spans every resident block
  assign elig_w = resident_w & warp_ready_i & ~held_nx_w;

  wis_issue_seq #(.NUM_WARPS(NUM_WARPS), .BEATS(BEATS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .elig_i   (elig_w),
    .active_o (active_w),
    .warp_o   (issue_warp_o),
    .beat_o   (issue_beat_o)
  );

  assign issue_valid_o = active_w;
  assign stall_o       = !active_w;

  AST_RELEASED_NOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (|release_w) |-> ((elig_w & ~warp_ready_i) == '0)); // R7
  AST_ELIG_RESIDENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((elig_w & ~resident_w) == '0)); // R4
endmodule

// File: tb/warp_issue_sched_tb.sv
module warp_issue_sched_tb_top;
  localparam int NW = 24;
  localparam int NB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NW-1:0] ready = '0, arrive = '0, lmask = '0;
  logic lvalid = 1'b0, rvalid = 1'b0;
  logic [2:0] lblk = '0, rblk = '0;
  logic issue_valid, stall;
  logic [4:0] issue_warp;
  logic [1:0] issue_beat;

  always #2.5 clk = ~clk;

  warp_issue_sched dut_i (
    .clk(clk), .rst_n(rst_n), .warp_ready_i(ready), .bar_arrive_i(arrive),
    .launch_valid_i(lvalid), .launch_block_i(lblk), .launch_mask_i(lmask),
    .retire_valid_i(rvalid), .retire_block_i(rblk),
    .issue_valid_o(issue_valid), .issue_warp_o(issue_warp),
    .issue_beat_o(issue_beat), .stall_o(stall));

  int checks = 0, fails = 0;
  logic [31:0] rng = 32'h1234_5677;

  // behavioural reference state (current and next)
  bit m_res[NW], n_res[NW], m_hold[NW], n_hold[NW];
  int m_blk[NW], n_blk[NW];
  bit m_act, n_act;
  int m_beat, n_beat, m_cur, n_cur, m_last, n_last;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] step(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13); y = y ^ (y >> 17); y = y ^ (y << 5);
    return y;
  endfunction

  task automatic model_reset();
    for (int w = 0; w < NW; w++) begin n_res[w] = 0; n_hold[w] = 0; n_blk[w] = 0; end
    n_act = 0; n_beat = 0; n_cur = 0; n_last = NW - 1;
  endtask

  task automatic model_next();
    bit gone[NW], arr[NW], rel[NB], elig[NW];
    int found;
    for (int b = 0; b < NB; b++) begin
      int tot, got;
      tot = 0; got = 0;
      for (int w = 0; w < NW; w++)
        if (m_res[w] && m_blk[w] == b) begin
          tot++;
          if (m_hold[w] || arrive[w]) got++;
        end
      rel[b] = (tot > 0) && (got == tot);
    end
    for (int w = 0; w < NW; w++) begin
      gone[w] = rvalid && m_res[w] && (m_blk[w] == int'(rblk));
      arr[w]  = m_res[w] && (m_hold[w] || arrive[w]);
      n_hold[w] = arr[w] && !rel[m_blk[w]] && !gone[w] && !(lvalid && lmask[w]);
      elig[w] = m_res[w] && ready[w] && !n_hold[w];
      n_res[w] = (m_res[w] && !gone[w]) || (lvalid && lmask[w]);
      n_blk[w] = (lvalid && lmask[w]) ? int'(lblk) : m_blk[w];
    end
    n_cur = m_cur; n_last = m_last;
    if (!m_act || m_beat == 3) begin
      found = -1;
      for (int k = 1; k <= NW; k++)
        if (found < 0 && elig[(m_last + k) % NW]) found = (m_last + k) % NW;
      n_beat = 0;
      n_act = (found >= 0);
      if (found >= 0) begin n_cur = found; n_last = found; end
    end else begin
      n_act = 1; n_beat = m_beat + 1;
    end
  endtask

  task automatic commit();
    m_res = n_res; m_hold = n_hold; m_blk = n_blk;
    m_act = n_act; m_beat = n_beat; m_cur = n_cur; m_last = n_last;
  endtask

  task automatic drive(input int k);
    arrive = '0; lvalid = 0; lmask = '0; rvalid = 0;
    rst_n = (k >= 4);
    rng = step(rng);
    if (k < 6) ready = '0;
    else if (k <= 40) ready = '1;
    else if (k <= 80) ready = rng[23:0] | rng[31:8];
    else if (k <= 90) ready = '0;
    else if (k <= 94) ready = 24'h000080;
    else if (k <= 175) ready = '1;
    else ready = rng[23:0] | rng[30:7];
    case (k)
      4:   begin lvalid = 1; lblk = 3'd0; lmask = 24'h00000F; end
      5:   begin lvalid = 1; lblk = 3'd5; lmask = 24'h0003F0; end
      95:  arrive = 24'h100007;           // warps 0..2 plus non-resident 20
      100: arrive = 24'h000001;           // repeat from held warp 0
      111: arrive = 24'h000008;           // last warp of block 0
      145: arrive = 24'h000030;           // partial arrival, block 5
      150: begin rvalid = 1; rblk = 3'd5; end
      151: begin lvalid = 1; lblk = 3'd5; lmask = 24'h0003F0; end
      155: arrive = 24'h0003C0;
      165: arrive = 24'h000030;
      175: begin lvalid = 1; lblk = 3'd2; lmask = 24'hFFFC00; end
      300: begin rvalid = 1; rblk = 3'd2; end
      320: begin lvalid = 1; lblk = 3'd7; lmask = 24'h03FC00; end
      330: begin lvalid = 1; lblk = 3'd3; lmask = 24'hFC0000; end
      420: begin rvalid = 1; rblk = 3'd0; end
      default: ;
    endcase
    if (k > 176 && k < 400 && (k % 9) == 0) arrive = 24'(1) << (rng[15:8] % NW);
  endtask

  initial begin
    int hold_bad, other_ok, rel_ok, nines, stale_bad;
    hold_bad = 0; other_ok = 0; rel_ok = 0; nines = 0; stale_bad = 0;
    model_reset(); commit();
    for (int k = 0; k < 470; k++) begin
      @(negedge clk);
      commit();
      chk(issue_valid == m_act, "R3", "issue_valid", int'(issue_valid), int'(m_act));
      chk(stall == !m_act, "R6", "stall", int'(stall), int'(!m_act));
      chk(int'(issue_beat) == m_beat, "R2", "beat", int'(issue_beat), m_beat);
      if (m_act) chk(int'(issue_warp) == m_cur, "R5", "warp", int'(issue_warp), m_cur);
      if (k == 2) begin // R1
        chk(!issue_valid && stall && issue_beat == 0, "R1", "reset idle", int'(issue_valid), 0);
      end
      if (k >= 93 && k <= 95) chk(issue_valid && issue_warp == 7, "R4", "only ready warp", int'(issue_warp), 7);
      if (k >= 97 && k <= 111 && issue_valid && issue_warp <= 2) hold_bad++;
      if (k >= 97 && k <= 111 && issue_valid && issue_warp >= 4 && issue_warp <= 9) other_ok++;
      if (k >= 113 && k <= 140 && issue_valid && issue_warp <= 2) rel_ok++;
      if (k >= 158 && k <= 166 && issue_valid && issue_warp >= 6 && issue_warp <= 9 && issue_beat == 0) nines++;
      if (k >= 422 && issue_valid && issue_beat == 0 && issue_warp <= 3) stale_bad++;
      drive(k);
      if (!rst_n) model_reset(); else model_next();
    end
    chk(hold_bad == 0, "R7", "held warp issued", hold_bad, 0);
    chk(other_ok > 0, "R8", "other block issues", other_ok, 1);
    chk(rel_ok > 0, "R10", "release after repeat arrival", rel_ok, 1);
    chk(nines == 0, "R9", "relaunch barrier state", nines, 0);
    chk(stale_bad == 0, "R9", "retired warp issued", stale_bad, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule